// File: doc/BRIEF.md
# Sub-word Load/Store Unit

This unit sits between a simple multi-cycle core and a 32-bit memory bus. The core hands it one access at a time: an operation code, a byte address and store data. The unit then runs that access on a bus whose request and response channels each have their own valid/ready handshake. Memory may take any number of cycles to accept a request or to return a response, so the unit waits on the handshakes and never assumes a fixed latency. It covers signed and unsigned byte and halfword loads, word loads, and byte, halfword and word stores.

For each access the unit sets the size code and the byte-lane write strobes, and it copies store data into every lane the access might use. On a load it shifts the addressed byte or halfword down from its lane and extends it with sign or zero. Misaligned halfword and word accesses never reach the bus. The unit ends them at once with an error. An error returned by the bus also reaches the core as an error, with a zero result.

The controller has four states. **IDLE**: ready for a new access. **ISSUE**: a request is offered on the bus. **WAIT**: the unit waits for the response. **FINISH**: a one-cycle completion pulse to the core. Each transition has a name:
- *accept* goes from IDLE to ISSUE on an aligned core request.
- *reject* goes from IDLE to FINISH on a misaligned request.
- *granted* goes from ISSUE to WAIT when req_ready is high.
- *answered* goes from WAIT to FINISH when rsp_valid is high.
- *retire* goes from FINISH back to IDLE.

Top module: `lsu_subword`

## Requirements
- R1: After reset, core_ready is 1, and req_valid, rsp_ready and core_done are 0.
- R2: core_op[3] is 1 for a store. core_op[2] is 1 for an unsigned load. core_op[1:0] gives the size: 00 is byte, 01 is halfword, 10 is word. req_size carries these same size codes, and req_we equals core_op[3]. req_addr is the full byte address.
- R3: req_wstrb has bit k set when byte lane k (bits 8k+7:8k) is written. A byte store sets 4'b0001 shifted left by addr[1:0]. A halfword store sets 4'b0011 shifted left by addr[1:0]. A word store sets 4'b1111. A load sets 4'b0000.
- R4: For a byte store, req_wdata holds the low store byte in all four lanes. For a halfword store, it holds the low store halfword in both halves. For a word store, it holds the store word unchanged.
- R5: A signed byte or halfword load returns the item at lane addr[1:0], sign-extended to 32 bits. For example, byte 0xFF returns 0xFFFFFFFF. A word load returns the response word unchanged.
- R6: An unsigned byte or halfword load returns the addressed item zero-extended. For example, byte 0xFF returns 0x000000FF.
- R7: A halfword access with addr[0] set is misaligned. So is a word access with addr[1:0] not equal to 0. Such an access issues no bus request. It completes with core_done in the cycle after it is accepted, with core_err=1 and core_rdata=0, and memory is left unchanged.
- R8: While req_valid is high and req_ready is low, req_valid stays high and req_addr, req_wdata, req_wstrb and req_size stay stable.
- R9: rsp_ready is raised only after the request handshake. The unit waits any number of cycles for rsp_valid. core_done rises in the cycle after the response handshake.
- R10: When rsp_err is 1 at the response handshake, core_err is 1 and core_rdata is 0. A successful store returns core_rdata=0.
- R11: At most one access is outstanding. core_ready is low from acceptance until the unit is idle again. core_valid is ignored meanwhile, and req_valid and rsp_ready are never high together.
- R12: core_done is a single-cycle pulse for each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core offers an access |
| core_ready | output | 1 | Unit can accept an access |
| core_op | input | 4 | {store, unsigned, size[1:0]} |
| core_addr | input | 32 | Byte address |
| core_wdata | input | 32 | Store data, right-aligned |
| core_done | output | 1 | Access complete (one cycle) |
| core_rdata | output | 32 | Extended load result |
| core_err | output | 1 | Misalignment or bus error |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus accepts request |
| req_addr | output | 32 | Request byte address |
| req_we | output | 1 | Write request |
| req_wdata | output | 32 | Lane-placed store data |
| req_size | output | 2 | Size code |
| req_wstrb | output | 4 | Byte-lane write strobes |
| rsp_valid | input | 1 | Bus response valid |
| rsp_ready | output | 1 | Unit accepts response |
| rsp_rdata | input | 32 | Response word |
| rsp_err | input | 1 | Bus error |

## Verification
The tests run loads at all four byte offsets of a word that holds bytes with the top bit both set and clear. This separates sign extension from zero extension, and it shows a wrong lane choice. Stores are tried with the sizes and offsets mixed, and each is read back as a word. This shows strobe placement, stray lane writes and data copying. The tests also vary the request and response latencies from zero to several cycles, and they cover misaligned halfword and word cases and an injected bus error. Together these check the handshake waits, the reject path that skips the bus, and that errors reach the core.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } size_e;

    typedef struct packed {
        logic  store;
        logic  uns;
        size_e size;
    } lsu_op_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } state_e;

    function automatic logic is_misaligned(input size_e sz, input logic [1:0] off);
        logic bad;
        bad = 1'b0;
        if (sz == SZ_HALF && off[0])        bad = 1'b1;
        if (sz == SZ_WORD && off != 2'b00)  bad = 1'b1;
        return bad;
    endfunction

endpackage

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                       is_store,
    input  size_e                      size,
    input  logic [$clog2(DATA_W/8)-1:0] offset,
    input  logic [DATA_W-1:0]          wdata_in,
    output logic [DATA_W-1:0]          wdata_out,
    output logic [DATA_W/8-1:0]        wstrb
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    wdata_out[8*i +: 8] = wdata_in[7:0];
                    wstrb[i]            = is_store && (offset == OFF_W'(i));
                end
                SZ_HALF: begin
                    wdata_out[8*i +: 8] = wdata_in[8*(i%2) +: 8];
                    wstrb[i]            = is_store && ((offset >> 1) == OFF_W'(i/2));
                end
                default: begin
                    wdata_out[8*i +: 8] = wdata_in[8*i +: 8];
                    wstrb[i]            = is_store;
                end
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e                        size,
    input  logic                         uns,
    input  logic [$clog2(DATA_W/8)-1:0]  offset,
    input  logic [DATA_W-1:0]            rdata,
    output logic [DATA_W-1:0]            value
);
    localparam int OFF_W = $clog2(DATA_W/8);

    logic [DATA_W-1:0] shifted;
    logic              fill;

    always_comb begin
        shifted = rdata >> {offset, 3'b000};
        unique case (size)
            SZ_BYTE: begin
                fill  = uns ? 1'b0 : shifted[7];
                value = {{(DATA_W-8){fill}}, shifted[7:0]};
            end
            SZ_HALF: begin
                fill  = uns ? 1'b0 : shifted[15];
                value = {{(DATA_W-16){fill}}, shifted[15:0]};
            end
            default: begin
                fill  = 1'b0;
                value = rdata;
            end
        endcase
    end

endmodule

// File: rtl/lsu_subword.sv
module lsu_subword
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_valid,
    output logic                core_ready,
    input  logic [3:0]          core_op,
    input  logic [ADDR_W-1:0]   core_addr,
    input  logic [DATA_W-1:0]   core_wdata,
    output logic                core_done,
    output logic [DATA_W-1:0]   core_rdata,
    output logic                core_err,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    output logic                req_we,
    output logic [DATA_W-1:0]   req_wdata,
    output logic [1:0]          req_size,
    output logic [DATA_W/8-1:0] req_wstrb,
    input  logic                rsp_valid,
    output logic                rsp_ready,
    input  logic [DATA_W-1:0]   rsp_rdata,
    input  logic                rsp_err
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    state_e            state, state_nx;
    lsu_op_t           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] result_q;
    logic              err_q;
    logic [DATA_W-1:0] load_val;
    lsu_op_t           op_in;
    logic              bad_in;

    assign op_in  = lsu_op_t'(core_op);
    assign bad_in = is_misaligned(op_in.size, core_addr[1:0]);

    lsu_store_pack #(.DATA_W(DATA_W)) u_pack (
        .is_store  (op_q.store),
        .size      (op_q.size),
        .offset    (addr_q[OFF_W-1:0]),
        .wdata_in  (wdata_q),
        .wdata_out (req_wdata),
        .wstrb     (req_wstrb)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
        .size   (op_q.size),
        .uns    (op_q.uns),
        .offset (addr_q[OFF_W-1:0]),
        .rdata  (rsp_rdata),
        .value  (load_val)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: accept, reject, granted, answered, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (core_valid) state_nx = bad_in ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  if (req_ready)  state_nx = ST_WAIT;
            ST_WAIT:   if (rsp_valid)  state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // access context and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            result_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (state == ST_IDLE && core_valid) begin
                op_q     <= op_in;
                addr_q   <= core_addr;
                wdata_q  <= core_wdata;
                result_q <= '0;
                err_q    <= bad_in;
            end
            if (state == ST_WAIT && rsp_valid) begin
                err_q    <= rsp_err;
                result_q <= (rsp_err || op_q.store) ? '0 : load_val;
            end
        end
    end

    // outputs
    always_comb begin
        core_ready = (state == ST_IDLE);
        req_valid  = (state == ST_ISSUE);
        rsp_ready  = (state == ST_WAIT);
        core_done  = (state == ST_FINISH);
        core_rdata = result_q;
        core_err   = err_q;
        req_addr   = addr_q;
        req_we     = op_q.store;
        req_size   = op_q.size;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_wstrb) && $stable(req_size)); // R8
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_size != 2'b11); // R2
    AST_LOAD_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_we |-> req_wstrb == '0); // R3
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_we && req_size == 2'b00 |-> $countones(req_wstrb) == 1); // R3
    AST_RSP_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> core_done); // R9
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        core_done && core_err |-> core_rdata == '0); // R10
    AST_SINGLE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && rsp_ready)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done); // R12

endmodule

// File: tb/lsu_subword_bench.sv
module lsu_subword_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [3:0] OP_LB  = 4'b0000, OP_LH  = 4'b0001, OP_LW = 4'b0010;
    localparam logic [3:0] OP_LBU = 4'b0100, OP_LHU = 4'b0101;
    localparam logic [3:0] OP_SB  = 4'b1000, OP_SH  = 4'b1001, OP_SW = 4'b1010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_valid = 1'b0;
    logic        core_ready;
    logic [3:0]  core_op = '0;
    logic [31:0] core_addr = '0;
    logic [31:0] core_wdata = '0;
    logic        core_done;
    logic [31:0] core_rdata;
    logic        core_err;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic        req_we;
    logic [31:0] req_wdata;
    logic [1:0]  req_size;
    logic [3:0]  req_wstrb;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata = '0;
    logic        rsp_err = 1'b0;

    lsu_subword u_lsu_subword (
        .clk(clk), .rst_n(rst_n),
        .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_done(core_done),
        .core_rdata(core_rdata), .core_err(core_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .req_size(req_size),
        .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [31:0] bus_mem [16];
    logic [31:0] ref_mem [16];

    int lat_req = 0, lat_rsp = 0;
    logic inj_err = 1'b0;
    int rs_phase = 0, rs_cnt = 0, req_count = 0;
    logic [31:0] hold_addr;
    logic [31:0] hold_wdata;
    logic [3:0]  hold_strb;
    logic        hold_we;

    logic [31:0] e_addr, e_wdata;
    logic [3:0]  e_strb;
    logic [1:0]  e_size;
    logic        e_we;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural bus: variable request and response latency
    always @(negedge clk) begin
        cycles++;
        case (rs_phase)
            0: if (req_valid) begin
                if (rs_cnt < lat_req) rs_cnt++;
                else begin
                    chk(req_addr == e_addr, "R2 req_addr", req_addr, e_addr);
                    chk(req_size == e_size, "R2 req_size", {30'd0, req_size}, {30'd0, e_size});
                    chk(req_we == e_we, "R2 req_we", {31'd0, req_we}, {31'd0, e_we});
                    chk(req_wstrb == e_strb, "R3 req_wstrb", {28'd0, req_wstrb}, {28'd0, e_strb});
                    if (e_we) chk(req_wdata == e_wdata, "R4 req_wdata", req_wdata, e_wdata);
                    hold_addr = req_addr; hold_wdata = req_wdata;
                    hold_strb = req_wstrb; hold_we = req_we;
                    req_ready = 1'b1;
                    req_count++;
                    rs_phase = 1; rs_cnt = 0;
                end
            end
            1: begin
                req_ready = 1'b0;
                if (hold_we && !inj_err)
                    for (int k = 0; k < 4; k++)
                        if (hold_strb[k]) bus_mem[hold_addr[5:2]][8*k +: 8] = hold_wdata[8*k +: 8];
                rs_phase = 2;
            end
            2: begin
                if (rs_cnt < lat_rsp) rs_cnt++;
                else begin
                    chk(rsp_ready == 1'b1, "R9 rsp_ready in wait", {31'd0, rsp_ready}, 32'd1);
                    rsp_valid = 1'b1;
                    rsp_err   = inj_err;
                    rsp_rdata = inj_err ? 32'hDEAD_BEEF : bus_mem[hold_addr[5:2]];
                    rs_phase = 3;
                end
            end
            default: begin
                rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = '0;
                rs_phase = 0; rs_cnt = 0;
            end
        endcase
    end

    task automatic do_op(input logic [3:0] op, input logic [31:0] addr, input logic [31:0] wd,
                         input logic inj, input int lq, input int lr, input bit poke, input string tag);
        logic [1:0] sz;
        logic [1:0] off;
        logic       mis;
        logic [31:0] exp_res, sh;
        int n;
        sz  = op[1:0];
        off = addr[1:0];
        mis = (sz == 2'b01 && off[0]) || (sz == 2'b10 && off != 2'b00);
        lat_req = lq; lat_rsp = lr; inj_err = inj;
        e_addr = addr; e_size = sz; e_we = op[3];
        case (sz)
            2'b00: begin e_strb = 4'b0001 << off; e_wdata = {4{wd[7:0]}}; end
            2'b01: begin e_strb = 4'b0011 << off; e_wdata = {2{wd[15:0]}}; end
            default: begin e_strb = 4'b1111; e_wdata = wd; end
        endcase
        if (!op[3]) e_strb = 4'b0000;
        sh = ref_mem[addr[5:2]] >> (8 * off);
        case (sz)
            2'b00: exp_res = op[2] ? {24'd0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
            2'b01: exp_res = op[2] ? {16'd0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
            default: exp_res = ref_mem[addr[5:2]];
        endcase
        if (op[3] || mis || inj) exp_res = '0;
        req_count = 0;
        @(negedge clk);
        core_valid = 1'b1; core_op = op; core_addr = addr; core_wdata = wd;
        @(negedge clk);
        core_valid = 1'b0;
        n = 1;
        if (poke && !core_done) begin
            chk(core_ready == 1'b0, {"R11 busy ready ", tag}, {31'd0, core_ready}, 32'd0);
            core_valid = 1'b1; core_op = OP_SW; core_addr = 32'h8000_0000; core_wdata = 32'h0BAD_0BAD;
        end
        while (!core_done && n < 400) begin
            @(negedge clk);
            n++;
        end
        core_valid = 1'b0;
        chk(core_done == 1'b1, {"R9 done ", tag}, {31'd0, core_done}, 32'd1);
        chk(core_rdata == exp_res, {"R5 R6 R10 result ", tag}, core_rdata, exp_res);
        chk(core_err == (mis | inj), {"R7 R10 err ", tag}, {31'd0, core_err}, {31'd0, mis | inj});
        chk(req_count == (mis ? 0 : 1), {"R7 R11 request count ", tag}, req_count, mis ? 0 : 1);
        if (mis) chk(n == 1, {"R7 reject latency ", tag}, n, 1);
        if (op[3] && !mis && !inj)
            for (int k = 0; k < 4; k++)
                if (e_strb[k]) ref_mem[addr[5:2]][8*k +: 8] = e_wdata[8*k +: 8];
        @(negedge clk);
        chk(core_done == 1'b0, {"R12 done pulse ", tag}, {31'd0, core_done}, 32'd0);
        chk(core_ready == 1'b1, {"R11 idle again ", tag}, {31'd0, core_ready}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin bus_mem[i] = '0; ref_mem[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(core_ready == 1'b1, "R1 ready", {31'd0, core_ready}, 32'd1);
        chk(req_valid == 1'b0, "R1 req_valid", {31'd0, req_valid}, 32'd0);
        chk(rsp_ready == 1'b0, "R1 rsp_ready", {31'd0, rsp_ready}, 32'd0);
        chk(core_done == 1'b0, "R1 done", {31'd0, core_done}, 32'd0);
        rst_n = 1'b1;

        do_op(OP_SW, 32'h8000_0000, 32'h80FF_7F01, 1'b0, 0, 0, 1'b0, "sw w0");
        do_op(OP_SW, 32'h8000_0004, 32'h1234_8765, 1'b0, 3, 2, 1'b0, "sw w1");
        do_op(OP_SW, 32'h8000_0008, 32'h0000_0000, 1'b0, 1, 5, 1'b0, "sw w2");
        // R5 R6 every byte offset, sign bits set and clear
        for (int o = 0; o < 4; o++) begin
            do_op(OP_LB,  32'h8000_0000 + o, '0, 1'b0, o, 3 - o, 1'b0, "lb");
            do_op(OP_LBU, 32'h8000_0000 + o, '0, 1'b0, 3 - o, o, 1'b0, "lbu");
        end
        do_op(OP_LH,  32'h8000_0004, '0, 1'b0, 0, 1, 1'b0, "lh lo");
        do_op(OP_LH,  32'h8000_0006, '0, 1'b0, 2, 0, 1'b0, "lh hi");
        do_op(OP_LHU, 32'h8000_0004, '0, 1'b0, 1, 1, 1'b0, "lhu lo");
        do_op(OP_LHU, 32'h8000_0006, '0, 1'b0, 0, 4, 1'b0, "lhu hi");
        do_op(OP_LW,  32'h8000_0004, '0, 1'b0, 6, 6, 1'b0, "lw");
        // R3 R4 sub-word stores then word read-back
        do_op(OP_SB, 32'h8000_0009, 32'h5555_55AB, 1'b0, 2, 1, 1'b0, "sb off1");
        do_op(OP_LW, 32'h8000_0008, '0, 1'b0, 0, 0, 1'b0, "lw after sb");
        do_op(OP_SH, 32'h8000_000A, 32'h7777_C3D2, 1'b0, 0, 2, 1'b0, "sh off2");
        do_op(OP_SB, 32'h8000_0003, 32'h0000_0042, 1'b0, 1, 0, 1'b0, "sb off3");
        do_op(OP_LW, 32'h8000_0008, '0, 1'b0, 1, 1, 1'b0, "lw after sh");
        do_op(OP_LW, 32'h8000_0000, '0, 1'b0, 1, 1, 1'b0, "lw after sb3");
        // R7 misaligned accesses
        do_op(OP_LH,  32'h8000_0005, '0, 1'b0, 0, 0, 1'b0, "lh mis");
        do_op(OP_LW,  32'h8000_0002, '0, 1'b0, 0, 0, 1'b0, "lw mis");
        do_op(OP_SW,  32'h8000_0007, 32'hFFFF_FFFF, 1'b0, 0, 0, 1'b0, "sw mis");
        do_op(OP_SH,  32'h8000_0003, 32'hFFFF_FFFF, 1'b0, 0, 0, 1'b0, "sh mis");
        do_op(OP_LW,  32'h8000_0004, '0, 1'b0, 0, 0, 1'b0, "lw after mis");
        // R10 bus error on load and store
        do_op(OP_LW, 32'h8000_0004, '0, 1'b1, 1, 2, 1'b0, "lw err");
        do_op(OP_SB, 32'h8000_0004, 32'h0000_00EE, 1'b1, 0, 1, 1'b0, "sb err");
        do_op(OP_LW, 32'h8000_0004, '0, 1'b0, 0, 0, 1'b0, "lw after err");
        // R11 core_valid while busy is ignored
        do_op(OP_LHU, 32'h8000_0002, '0, 1'b0, 4, 4, 1'b1, "busy poke");
        do_op(OP_LW,  32'h8000_0000, '0, 1'b0, 0, 0, 1'b0, "lw after poke");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule